// File: doc/BRIEF.md
# CAN Bit Timing and Receive Sampler

This block divides each CAN bit into time quanta and decides, quantum by quantum, where a bit starts, where the receive line is sampled and when the transmitter may drive its next bit. An external prescaler supplies a one-cycle quantum enable pulse. The quantum index moves only on that pulse. An 8-bit timing value sets the lengths of the two time segments and chooses between one sample and a three-sample majority vote.

Each bit begins with a one-quantum synchronization segment, in which bus edges are expected. Time segment 1 follows, and then time segment 2. The sample point lies on the boundary between segment 1 and segment 2. In majority mode the two extra samples come from the two quanta just before the sample-point quantum, so the sample point gives the last of the three votes. While the protocol layer reports the bus idle, a recessive-to-dominant edge on the receive line puts the quantum index back to the synchronization segment (hard synchronization).

Top module: `can_bit_timing`

## Requirements
- R1: At reset the timing value is 0 (single sampling, both segment fields 0), so a bit lasts 3 quanta and is sampled on the pulse of quantum index 1. Both strobes are low after reset.
- R2: A write with `cfg_wr_i` high loads `cfg_wdata_i` on that clock edge. Bit 7 selects majority mode (1) or single sampling (0), bits 6:4 hold the segment 2 field F2 and bits 3:0 hold the segment 1 field F1.
- R3: A bit lasts F1+F2+3 quanta: index 0 is synchronization, indices 1..F1+1 are segment 1 and indices F1+2..F1+F2+2 are segment 2. The index changes only in a cycle with `tq_en_i` high.
- R4: `bit_valid_o` is high for exactly one cycle, the cycle after the `tq_en_i` pulse of index F1+1 (the sample point).
- R5: With single sampling, `bit_o` equals `rx_i` as it was during the sample-point pulse.
- R6: In majority mode with F1 >= 2, `bit_o` is the majority of `rx_i` taken at the pulses of indices F1-1, F1 and F1+1.
- R7: In majority mode with F1 < 2, the block samples once, at the sample point, exactly as in R5.
- R8: `tx_point_o` is high for one cycle, the cycle after the `tq_en_i` pulse of the last index F1+F2+2, which is the start of the next synchronization segment. It is never high in the same cycle as `bit_valid_o`.
- R9: When `idle_i` is high and `rx_i` goes from 1 in one clock to 0 in the next, the index returns to 0 and `tx_point_o` pulses the following cycle. The next `tq_en_i` pulse then counts as the synchronization quantum, and no sample is taken in the cycle of the edge.
- R10: A falling edge on `rx_i` while `idle_i` is low leaves the quantum index and both strobes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tq_en_i | input | 1 | One-cycle pulse per time quantum |
| rx_i | input | 1 | Synchronized receive line, 1 = recessive |
| idle_i | input | 1 | Bus idle, enables hard synchronization |
| cfg_wr_i | input | 1 | Timing value write strobe |
| cfg_wdata_i | input | 8 | Timing value: mode bit 7, F2 in 6:4, F1 in 3:0 |
| bit_o | output | 1 | Sampled bit value |
| bit_valid_o | output | 1 | `bit_o` is new in this cycle |
| tx_point_o | output | 1 | Start of synchronization segment, drive the next bit |

## Verification
The timing value takes effect one cycle after its write. `bit_valid_o` and `tx_point_o` each go high one cycle after the `tq_en_i` pulse that qualifies them, and the hard-sync strobe rises one cycle after the edge clock. The bench drives each quantum pulse at a falling clock edge and reads the strobes at the next falling edge, one register later. Each strobe is credited to the quantum index of the pulse that caused it. The bench compares that index with F1+1 and F1+F2+2 as worked out from the timing value, and compares the voted bit with the pattern it drove on the quanta before the sample point.

// File: rtl/can_bt_pkg.sv
package can_bt_pkg;
  localparam int unsigned SEG1_W  = 4;
  localparam int unsigned SEG2_W  = 3;
  localparam int unsigned N_EXTRA = 2;   // extra votes before the sample point
  localparam int unsigned CFG_W   = 1 + SEG2_W + SEG1_W;
  localparam int unsigned CNT_W   = $clog2((1 << SEG1_W) + (1 << SEG2_W) + 1);

  typedef logic [CNT_W-1:0] qidx_t;

  typedef struct packed {
    logic              triple;
    logic [SEG2_W-1:0] seg2;
    logic [SEG1_W-1:0] seg1;
  } bt_cfg_t;

  function automatic qidx_t sample_idx(logic [SEG1_W-1:0] s1);
    return qidx_t'(s1) + qidx_t'(1);
  endfunction

  function automatic qidx_t last_idx(logic [SEG1_W-1:0] s1, logic [SEG2_W-1:0] s2);
    return qidx_t'(s1) + qidx_t'(s2) + qidx_t'(2);
  endfunction
endpackage

// File: rtl/can_bt_cfg_reg.sv
module can_bt_cfg_reg
  import can_bt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output bt_cfg_t          cfg_o
);
  bt_cfg_t cfg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cfg_q <= '0;
    else if (wr_i) cfg_q <= bt_cfg_t'(wdata_i);
  end

  assign cfg_o = cfg_q;

  assert_cfg_load_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> cfg_o == bt_cfg_t'($past(wdata_i)));
endmodule

// File: rtl/can_bt_quanta.sv
module can_bt_quanta
  import can_bt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tq_en_i,
  input  logic              rx_i,
  input  logic              idle_i,
  input  logic [SEG1_W-1:0] seg1_i,
  input  logic [SEG2_W-1:0] seg2_i,
  output qidx_t             q_o,
  output logic              hsync_o,
  output logic              tx_point_o
);
  qidx_t q_q;
  qidx_t last;
  logic  rx_prev_q;
  logic  wrap;
  logic  tx_q;

  assign last    = last_idx(seg1_i, seg2_i);
  // >= also recovers if a shorter timing is written mid-bit
  assign wrap    = q_q >= last;
  assign hsync_o = idle_i & rx_prev_q & ~rx_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_prev_q <= 1'b1;
      q_q       <= '0;
      tx_q      <= 1'b0;
    end else begin
      rx_prev_q <= rx_i;
      tx_q      <= hsync_o | (tq_en_i & wrap);
      if (hsync_o)      q_q <= '0;
      else if (tq_en_i) q_q <= wrap ? '0 : q_q + qidx_t'(1);
    end
  end

  assign q_o        = q_q;
  assign tx_point_o = tx_q;

  assert_hsync_restart_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hsync_o |=> (q_o == '0) && tx_point_o);

  assert_hold_without_tq_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tq_en_i && !hsync_o) |=> $stable(q_o));

  assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tq_en_i && !hsync_o && q_o < last) |=> q_o == $past(q_o) + qidx_t'(1));

  assert_tx_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_point_o |=> !tx_point_o);
endmodule

// File: rtl/can_bt_sampler.sv
module can_bt_sampler
  import can_bt_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tq_en_i,
  input  logic              hsync_i,
  input  logic              rx_i,
  input  qidx_t             q_i,
  input  logic [SEG1_W-1:0] seg1_i,
  input  logic              triple_i,
  output logic              bit_o,
  output logic              bit_valid_o
);
  qidx_t              sp;
  logic               tick;
  logic               vote_en;
  logic [N_EXTRA-1:0] early;
  logic               bit_q;
  logic               valid_q;

  assign sp      = sample_idx(seg1_i);
  assign tick    = tq_en_i & ~hsync_i;
  // majority needs N_EXTRA quanta of segment 1 ahead of the sample point
  assign vote_en = triple_i & (32'(seg1_i) >= N_EXTRA);

  for (genvar k = 0; k < N_EXTRA; k++) begin : g_early
    localparam qidx_t OFS = qidx_t'(N_EXTRA - k);
    logic s_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                        s_q <= 1'b0;
      else if (tick && (q_i == sp - OFS)) s_q <= rx_i;
    end
    assign early[k] = s_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bit_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= tick && (q_i == sp);
      if (tick && (q_i == sp))
        bit_q <= vote_en ? ($countones({early, rx_i}) > (N_EXTRA / 2)) : rx_i;
    end
  end

  assign bit_o       = bit_q;
  assign bit_valid_o = valid_q;

  assert_valid_after_tq_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bit_valid_o) |-> $past(tq_en_i) && !$past(hsync_i));

  assert_valid_single_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_valid_o |=> !bit_valid_o);

  assert_single_sample_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (bit_valid_o && !$past(vote_en)) |-> bit_o == $past(rx_i));

  assert_hold_bit_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_valid_o |-> $stable(bit_o));
endmodule

// File: rtl/can_bit_timing.sv
module can_bit_timing
  import can_bt_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tq_en_i,
  input  logic             rx_i,
  input  logic             idle_i,
  input  logic             cfg_wr_i,
  input  logic [CFG_W-1:0] cfg_wdata_i,
  output logic             bit_o,
  output logic             bit_valid_o,
  output logic             tx_point_o
);
  bt_cfg_t cfg;
  qidx_t   q;
  logic    hsync;

  can_bt_cfg_reg u_cfg (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (cfg_wr_i),
    .wdata_i (cfg_wdata_i),
    .cfg_o   (cfg)
  );

  can_bt_quanta u_quanta (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .tq_en_i    (tq_en_i),
    .rx_i       (rx_i),
    .idle_i     (idle_i),
    .seg1_i     (cfg.seg1),
    .seg2_i     (cfg.seg2),
    .q_o        (q),
    .hsync_o    (hsync),
    .tx_point_o (tx_point_o)
  );

  can_bt_sampler u_sampler (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tq_en_i     (tq_en_i),
    .hsync_i     (hsync),
    .rx_i        (rx_i),
    .q_i         (q),
    .seg1_i      (cfg.seg1),
    .triple_i    (cfg.triple),
    .bit_o       (bit_o),
    .bit_valid_o (bit_valid_o)
  );

  assert_no_overlap_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_valid_o && tx_point_o));

  assert_idle_edge_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!idle_i && !tq_en_i) |=> !tx_point_o && !bit_valid_o);
endmodule

// File: tb/sim_can_bit_timing.sv
`timescale 1ns/1ps
module sim_can_bit_timing;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tq_en = 1'b0;
  logic       rx = 1'b1;
  logic       idle = 1'b0;
  logic       cfg_wr = 1'b0;
  logic [7:0] cfg_wdata = 8'h00;
  logic       bit_o, bit_valid_o, tx_point_o;

  int n_chk = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  can_bit_timing u0 (
    .clk_i(clk), .rst_ni(rst_n), .tq_en_i(tq_en), .rx_i(rx), .idle_i(idle),
    .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata),
    .bit_o(bit_o), .bit_valid_o(bit_valid_o), .tx_point_o(tx_point_o)
  );

  // {timing value, votes at F1-1/F1/F1+1 as [2]/[1]/[0], expected bit}
  localparam logic [11:0] VEC [10] = '{
    {8'h00, 3'b001, 1'b1},
    {8'h23, 3'b110, 1'b0},
    {8'h23, 3'b001, 1'b1},
    {8'hA3, 3'b110, 1'b1},
    {8'hA3, 3'b001, 1'b0},
    {8'hA3, 3'b011, 1'b1},
    {8'hF7, 3'b100, 1'b0},
    {8'h82, 3'b110, 1'b1},
    {8'h81, 3'b110, 1'b0},
    {8'h7F, 3'b101, 1'b1}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1'b1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic hard_sync();
    @(negedge clk); idle = 1'b1; rx = 1'b1;
    @(negedge clk); rx = 1'b0;
    @(negedge clk);
    check(tx_point_o == 1'b1, "R9 tx strobe after idle edge", int'(tx_point_o), 1);
    idle = 1'b0;
  endtask

  task automatic pulse(input logic r, output logic v, output logic b, output logic t);
    @(negedge clk); rx = r; tq_en = 1'b1;
    @(negedge clk); v = bit_valid_o; b = bit_o; t = tx_point_o; tq_en = 1'b0;
  endtask

  // pulses with index from..to; votes placed around t1, rx=1 elsewhere
  task automatic run_pulses(input int from, input int to, input int t1, input logic [2:0] pat,
                            output int vcnt, output int vpos, output logic vbit, output int tpos);
    logic v, b, t, r;
    vcnt = 0; vpos = -1; vbit = 1'b0; tpos = -1;
    for (int j = from; j <= to; j++) begin
      r = 1'b1;
      if (j == t1 - 2) r = pat[2];
      if (j == t1 - 1) r = pat[1];
      if (j == t1)     r = pat[0];
      pulse(r, v, b, t);
      if (v) begin vcnt++; vpos = j; vbit = b; end
      if (t && tpos < 0) tpos = j;
    end
  endtask

  initial begin
    #(8ns * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int vcnt, vpos, tpos;
    logic vbit;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 outputs after reset
    check(bit_valid_o == 1'b0, "R1 bit_valid_o after reset", int'(bit_valid_o), 0);
    check(tx_point_o == 1'b0, "R1 tx_point_o after reset", int'(tx_point_o), 0);

    // R1 default timing: 3-quantum bit, sample at index 1
    run_pulses(0, 3, 1, 3'b000, vcnt, vpos, vbit, tpos);
    check(vcnt == 1 && vpos == 1, "R1 default sample index", vpos, 1);
    check(vbit == 1'b0, "R1 default sampled bit", int'(vbit), 0);
    check(tpos == 2, "R1 default tx index", tpos, 2);

    // R3 no quantum pulses, no progress
    begin
      int seen = 0;
      repeat (20) begin
        @(negedge clk);
        if (bit_valid_o || tx_point_o) seen++;
      end
      check(seen == 0, "R3 strobes without tq_en", seen, 0);
    end

    // vector table: R2 field layout, R4 position, R5/R6/R7 value, R8 transmit point
    foreach (VEC[i]) begin
      logic [7:0] c;
      logic [2:0] pat;
      logic       exp;
      int f1, f2, t1, last;
      string tag;
      c = VEC[i][11:4]; pat = VEC[i][3:1]; exp = VEC[i][0];
      f1 = int'(c[3:0]); f2 = int'(c[6:4]); t1 = f1 + 1; last = f1 + f2 + 2;
      tag = !c[7] ? "R5 single bit" : (f1 >= 2 ? "R6 majority bit" : "R7 fallback bit");
      write_cfg(c);
      hard_sync();
      run_pulses(0, last + 1, t1, pat, vcnt, vpos, vbit, tpos);
      check(vcnt == 1 && vpos == t1, "R2 R4 sample index", vpos, t1);
      check(vbit == exp, tag, int'(vbit), int'(exp));
      check(tpos == last, "R2 R3 R8 tx index", tpos, last);
    end

    // R10 edge while not idle is ignored
    write_cfg(8'h23);
    hard_sync();
    run_pulses(0, 1, 4, 3'b111, vcnt, vpos, vbit, tpos);
    @(negedge clk); rx = 1'b1;
    @(negedge clk); rx = 1'b0;
    @(negedge clk);
    check(tx_point_o == 1'b0, "R10 tx after busy edge", int'(tx_point_o), 0);
    check(bit_valid_o == 1'b0, "R10 valid after busy edge", int'(bit_valid_o), 0);
    rx = 1'b1;
    run_pulses(2, 8, 4, 3'b111, vcnt, vpos, vbit, tpos);
    check(vcnt == 1 && vpos == 4, "R10 sample index kept", vpos, 4);
    check(tpos == 7, "R10 tx index kept", tpos, 7);

    // R9 hard sync mid-bit restarts the index
    hard_sync();
    run_pulses(0, 2, 4, 3'b111, vcnt, vpos, vbit, tpos);
    hard_sync();
    run_pulses(0, 8, 4, 3'b111, vcnt, vpos, vbit, tpos);
    check(vcnt == 1 && vpos == 4, "R9 sample index after restart", vpos, 4);
    check(tpos == 7, "R9 tx index after restart", tpos, 7);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule